// File: doc/BRIEF.md
# DDR Write Beat Capture with Byte Masking

This block sits at the receive side of a double-data-rate write path. It takes data from the DQ bus on both edges of the data strobe: a rising edge carries an even-numbered beat and the following falling edge carries the next odd beat. Each beat has a byte-mask input with zero latency. A mask bit that is high on an edge stops the matching data byte of that same beat from being written. The block presents each rising/falling pair of beats to the storage array as a single word. The word carries the beat number and one write enable for each byte.

Capture runs only while the write-burst indication is high. The block counts the beats of a burst up to the selected burst length and then ignores any further strobe edges. Strobe edges outside a write burst produce no write, and the mask input has no effect on them. This covers strobe activity that belongs to reads, where masking does not apply. The storage array can take the pair output at any point in the strobe period that follows the falling edge, because the output is held for that whole period.

Top module: `ddr_wmask_capture`

## Requirements
- R1: Beat 0 is the beat taken on the first rising strobe edge at which `wr_burst` is high after it was low. Rising edges carry even beats and falling edges carry odd beats. After each falling edge, `beat_idx` holds the even beat number of the pair, the low half of `beat_data` holds the even beat, and the high half holds the odd beat.
- R2: When a mask bit is high on a falling edge, the matching odd-beat byte enable is low for that pair. The data byte it belongs to is not written.
- R3: When a mask bit is high on a rising edge, the matching even-beat byte enable is low for that pair. Each edge's mask qualifies only the beat taken on that same edge.
- R4: `bl_sel` selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8, and 3 also gives 8. After that many beats, further strobe edges give all-zero `beat_we` until `wr_burst` has been low at a rising edge.
- R5: Strobe edges that occur while `wr_burst` is low give all-zero `beat_we`, whatever `dm` is. A rising edge with `wr_burst` low restarts beat numbering at 0.
- R6: Reset is active low and synchronous to the strobe. It clears `beat_we`, `beat_idx` and `beat_data` at the next falling edge, and the beat count at the next rising edge.
- R7: Mask bit i covers data bits 8i+7 down to 8i. `beat_we` bit i enables byte i of the even beat, and bit MASK_W+i enables byte i of the odd beat.
- R8: A storage array that writes only the bytes enabled by `beat_we` ends a burst with the masked bytes unchanged and every unmasked byte holding its new data.
- R9: `beat_we` is nonzero only for the one strobe period that follows a falling edge which completed a captured pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dqs | input | 1 | Data strobe; both edges capture data |
| rst_n | input | 1 | Active-low reset, synchronous to the strobe |
| wr_burst | input | 1 | High while a write burst is in progress |
| bl_sel | input | 2 | Burst length select (2, 4, 8, 8) |
| dq | input | DQ_W | Write data bus |
| dm | input | DQ_W/8 | Byte mask, high means do not write |
| beat_idx | output | $clog2(MAX_BL) | Even beat number of the presented pair |
| beat_data | output | 2*DQ_W | Odd beat (high half) and even beat (low half) |
| beat_we | output | 2*DQ_W/8 | Byte write enables, odd beat in the high half |

## Verification
On every strobe edge, the assertions check the following: a new burst starts at beat 0; an idle rising edge captures nothing; the beat count stays within the burst length; a fully masked edge yields zero enables for its beat; and a period without a capture yields no enable. Only the bench's scenarios can show the per-byte combinations of mask and data across a whole burst, and the resulting contents of a model storage array, including the bytes that keep their old values. The same holds for how each burst-length code ends the capture, and for the effect of a reset in the middle of a burst.

// File: rtl/ddr_wmask_pkg.sv
// Shared definitions for the DDR write mask capture block.
// Assumes burst lengths never exceed the MAX_BL parameter of the users.
package ddr_wmask_pkg;

    typedef enum logic [1:0] {
        BLS_2  = 2'd0,
        BLS_4  = 2'd1,
        BLS_8  = 2'd2,
        BLS_8B = 2'd3
    } bl_code_e;

    // Number of beats that a burst-length code stands for.
    function automatic int unsigned beats_for(input logic [1:0] code);
        case (code)
            BLS_2:   beats_for = 2;
            BLS_4:   beats_for = 4;
            default: beats_for = 8;
        endcase
    endfunction

endpackage

// File: rtl/wmask_lane_enable.sv
// Turns a per-byte mask into per-byte write enables for one beat.
// Assumes mask high means the byte is not written; valid gates all lanes.
module wmask_lane_enable #(
    parameter int MASK_W = 2
) (
    input  logic              valid,
    input  logic [MASK_W-1:0] mask,
    output logic [MASK_W-1:0] en
);

    for (genvar i = 0; i < MASK_W; i++) begin : g_lane
        // One lane: enabled when the beat is real and its mask bit is low.
        assign en[i] = valid & ~mask[i];
    end

endmodule

// File: rtl/wmask_rise_capture.sv
// Rising-edge half of the capture: counts beats of a write burst and
// holds the even beat with its mask until the following falling edge.
// Assumes wr_burst is stable around rising strobe edges.
module wmask_rise_capture
    import ddr_wmask_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int MASK_W = DQ_W / 8,
    parameter int MAX_BL = 8,
    parameter int IDX_W  = $clog2(MAX_BL)
) (
    input  logic              dqs,
    input  logic              rst_n,
    input  logic              wr_burst,
    input  logic [1:0]        bl_sel,
    input  logic [DQ_W-1:0]   dq,
    input  logic [MASK_W-1:0] dm,
    output logic              rise_valid,
    output logic [IDX_W-1:0]  rise_idx,
    output logic [DQ_W-1:0]   rise_data,
    output logic [MASK_W-1:0] rise_mask
);

    localparam int CNT_W = IDX_W + 1;

    logic [CNT_W-1:0] beat_cnt;
    logic [CNT_W-1:0] beat_limit;

    // Burst length in beats, clipped to what the counter can address.
    always_comb begin
        if (beats_for(bl_sel) > MAX_BL)
            beat_limit = CNT_W'(MAX_BL);
        else
            beat_limit = CNT_W'(beats_for(bl_sel));
    end

    // Capture the even beat and advance the count by a beat pair.
    always_ff @(posedge dqs) begin
        if (!rst_n) begin
            beat_cnt   <= '0;
            rise_valid <= 1'b0;
            rise_idx   <= '0;
            rise_data  <= '0;
            rise_mask  <= '0;
        end else if (!wr_burst) begin
            beat_cnt   <= '0;
            rise_valid <= 1'b0;
        end else if (beat_cnt < beat_limit) begin
            rise_valid <= 1'b1;
            rise_idx   <= beat_cnt[IDX_W-1:0];
            rise_data  <= dq;
            rise_mask  <= dm;
            beat_cnt   <= beat_cnt + CNT_W'(2);
        end else begin
            rise_valid <= 1'b0;
        end
    end

    assert_first_beat_zero_R1: assert property (@(posedge dqs) disable iff (!rst_n)
        $rose(wr_burst) |=> (rise_valid && rise_idx == '0));

    assert_idle_no_capture_R5: assert property (@(posedge dqs) disable iff (!rst_n)
        !wr_burst |=> !rise_valid);

    assert_count_bound_R4: assert property (@(posedge dqs) disable iff (!rst_n)
        beat_cnt <= CNT_W'(MAX_BL));

endmodule

// File: rtl/wmask_fall_capture.sv
// Falling-edge half of the capture: joins the odd beat with the held
// even beat and registers the pair with its byte write enables.
// Assumes the rising-edge half updates only on rising strobe edges.
module wmask_fall_capture #(
    parameter int DQ_W   = 16,
    parameter int MASK_W = DQ_W / 8,
    parameter int MAX_BL = 8,
    parameter int IDX_W  = $clog2(MAX_BL)
) (
    input  logic                dqs,
    input  logic                rst_n,
    input  logic                rise_valid,
    input  logic [IDX_W-1:0]    rise_idx,
    input  logic [DQ_W-1:0]     rise_data,
    input  logic [MASK_W-1:0]   rise_mask,
    input  logic [DQ_W-1:0]     dq,
    input  logic [MASK_W-1:0]   dm,
    output logic [IDX_W-1:0]    beat_idx,
    output logic [2*DQ_W-1:0]   beat_data,
    output logic [2*MASK_W-1:0] beat_we
);

    logic [MASK_W-1:0] even_en;
    logic [MASK_W-1:0] odd_en;

    wmask_lane_enable #(.MASK_W(MASK_W)) i_even_lanes (
        .valid (rise_valid),
        .mask  (rise_mask),
        .en    (even_en)
    );

    wmask_lane_enable #(.MASK_W(MASK_W)) i_odd_lanes (
        .valid (rise_valid),
        .mask  (dm),
        .en    (odd_en)
    );

    // Register the beat pair and its enables for one strobe period.
    always_ff @(negedge dqs) begin
        if (!rst_n) begin
            beat_idx  <= '0;
            beat_data <= '0;
            beat_we   <= '0;
        end else begin
            beat_we <= {odd_en, even_en};
            if (rise_valid) begin
                beat_idx  <= rise_idx;
                beat_data <= {dq, rise_data};
            end
        end
    end

    assert_no_capture_no_we_R9: assert property (@(negedge dqs) disable iff (!rst_n)
        !rise_valid |=> beat_we == '0);

    assert_odd_mask_blocks_R2: assert property (@(negedge dqs) disable iff (!rst_n)
        (dm == '1) |=> beat_we[2*MASK_W-1:MASK_W] == '0);

    assert_even_mask_blocks_R3: assert property (@(negedge dqs) disable iff (!rst_n)
        (rise_mask == '1) |=> beat_we[MASK_W-1:0] == '0);

endmodule

// File: rtl/ddr_wmask_capture.sv
// Top of the DDR write capture: one beat per strobe edge, byte masks
// with zero latency, pairs presented after each falling edge.
// Assumes strobe-to-clock alignment is handled outside this block.
module ddr_wmask_capture #(
    parameter int DQ_W   = 16,
    parameter int MAX_BL = 8,
    localparam int MASK_W = DQ_W / 8,
    localparam int IDX_W  = $clog2(MAX_BL)
) (
    input  logic                dqs,
    input  logic                rst_n,
    input  logic                wr_burst,
    input  logic [1:0]          bl_sel,
    input  logic [DQ_W-1:0]     dq,
    input  logic [MASK_W-1:0]   dm,
    output logic [IDX_W-1:0]    beat_idx,
    output logic [2*DQ_W-1:0]   beat_data,
    output logic [2*MASK_W-1:0] beat_we
);

    logic              rise_valid;
    logic [IDX_W-1:0]  rise_idx;
    logic [DQ_W-1:0]   rise_data;
    logic [MASK_W-1:0] rise_mask;

    wmask_rise_capture #(
        .DQ_W(DQ_W), .MASK_W(MASK_W), .MAX_BL(MAX_BL), .IDX_W(IDX_W)
    ) i_rise (
        .dqs        (dqs),
        .rst_n      (rst_n),
        .wr_burst   (wr_burst),
        .bl_sel     (bl_sel),
        .dq         (dq),
        .dm         (dm),
        .rise_valid (rise_valid),
        .rise_idx   (rise_idx),
        .rise_data  (rise_data),
        .rise_mask  (rise_mask)
    );

    wmask_fall_capture #(
        .DQ_W(DQ_W), .MASK_W(MASK_W), .MAX_BL(MAX_BL), .IDX_W(IDX_W)
    ) i_fall (
        .dqs        (dqs),
        .rst_n      (rst_n),
        .rise_valid (rise_valid),
        .rise_idx   (rise_idx),
        .rise_data  (rise_data),
        .rise_mask  (rise_mask),
        .dq         (dq),
        .dm         (dm),
        .beat_idx   (beat_idx),
        .beat_data  (beat_data),
        .beat_we    (beat_we)
    );

endmodule

// File: tb/test_ddr_wmask_capture.sv
module test_ddr_wmask_capture;

    localparam int STROBE_PERIOD = 10;
    localparam int Q = STROBE_PERIOD / 4;
    localparam int NVEC = 6;

    // Vector fields: {bl_sel[1:0], mask per beat (beat b at bits 2b+1:2b), seed[7:0]}
    localparam logic [25:0] VECS [NVEC] = '{
        {2'd2, 16'h0000, 8'h11},
        {2'd2, 16'hFFFF, 8'h22},
        {2'd2, 16'h9C36, 8'h33},
        {2'd0, 16'h0006, 8'h44},
        {2'd1, 16'h00B1, 8'h55},
        {2'd3, 16'h4821, 8'h66}
    };

    logic        dqs = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_burst = 1'b0;
    logic [1:0]  bl_sel = 2'd2;
    logic [15:0] dq = '0;
    logic [1:0]  dm = '0;
    logic [2:0]  beat_idx;
    logic [31:0] beat_data;
    logic [3:0]  beat_we;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] mem_dut [8];
    logic [15:0] mem_exp [8];

    ddr_wmask_capture i_ddr_wmask_capture (
        .dqs, .rst_n, .wr_burst, .bl_sel, .dq, .dm,
        .beat_idx, .beat_data, .beat_we
    );

    always #(STROBE_PERIOD/2) dqs = ~dqs;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] beat_word(input logic [7:0] seed, input int b);
        return {seed ^ 8'(b * 17), 8'(seed + b)};
    endfunction

    // Starts and ends at falling edge + Q; drives a rising beat, then a falling beat.
    task automatic do_pair(input logic [15:0] d0, input logic [1:0] m0,
                           input logic [15:0] d1, input logic [1:0] m1);
        dq = d0; dm = m0;
        @(posedge dqs); #Q;
        dq = d1; dm = m1;
        @(negedge dqs); #Q;
    endtask

    // Writes the enabled bytes of the presented pair into the DUT-driven model.
    task automatic apply_dut_write();
        for (int h = 0; h < 2; h++) begin
            for (int by = 0; by < 2; by++) begin
                if (beat_we[2*h+by])
                    mem_dut[int'(beat_idx) + h][8*by +: 8] = beat_data[16*h + 8*by +: 8];
            end
        end
    endtask

    initial begin
        #(STROBE_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge dqs);
        #Q;
        check(beat_we == 4'h0, "R6", "we in reset", 32'(beat_we), 32'h0);
        check(beat_idx == 3'd0, "R6", "idx in reset", 32'(beat_idx), 32'h0);
        check(beat_data == 32'h0, "R6", "data in reset", beat_data, 32'h0);
        rst_n = 1'b1;
        do_pair(16'h1111, 2'b00, 16'h2222, 2'b00);
        check(beat_we == 4'h0, "R5", "idle pair after reset", 32'(beat_we), 32'h0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  bls;
            logic [15:0] mk;
            logic [7:0]  sd;
            int nb;
            {bls, mk, sd} = VECS[v];
            nb = (bls == 2'd0) ? 2 : (bls == 2'd1) ? 4 : 8;
            for (int i = 0; i < 8; i++) begin
                mem_dut[i] = 16'hA500 | 16'(i);
                mem_exp[i] = 16'hA500 | 16'(i);
            end
            bl_sel = bls;
            wr_burst = 1'b1;
            for (int p = 0; p < nb / 2; p++) begin
                logic [1:0] m0, m1;
                logic [3:0] exp_we;
                m0 = mk[4*p +: 2];
                m1 = mk[4*p + 2 +: 2];
                do_pair(beat_word(sd, 2*p), m0, beat_word(sd, 2*p + 1), m1);
                exp_we = {~m1, ~m0};
                check(beat_idx == 3'(2*p), "R1", "pair index", 32'(beat_idx), 32'(2*p));
                check(beat_data == {beat_word(sd, 2*p + 1), beat_word(sd, 2*p)},
                      "R1", "pair data order", beat_data,
                      {beat_word(sd, 2*p + 1), beat_word(sd, 2*p)});
                check(beat_we[1:0] == exp_we[1:0], "R3", "even beat enables",
                      32'(beat_we[1:0]), 32'(exp_we[1:0]));
                check(beat_we[3:2] == exp_we[3:2], "R2", "odd beat enables R7",
                      32'(beat_we[3:2]), 32'(exp_we[3:2]));
                apply_dut_write();
                for (int h = 0; h < 2; h++)
                    for (int by = 0; by < 2; by++)
                        if (!mk[2*(2*p + h) + by])
                            mem_exp[2*p + h][8*by +: 8] = beat_word(sd, 2*p + h) >> (8*by);
            end
            // R4: an extra pair past the burst length is ignored
            do_pair(16'hDEAD, 2'b00, 16'hBEEF, 2'b00);
            check(beat_we == 4'h0, "R4", "edges after burst end", 32'(beat_we), 32'h0);
            apply_dut_write();
            // R5: strobe edges with the burst inactive
            wr_burst = 1'b0;
            do_pair(16'hCAFE, 2'b00, 16'hF00D, 2'b00);
            check(beat_we == 4'h0, "R5", "edges outside burst", 32'(beat_we), 32'h0);
            apply_dut_write();
            // R8: model storage contents
            for (int i = 0; i < 8; i++)
                check(mem_dut[i] == mem_exp[i], "R8", "storage word",
                      32'(mem_dut[i]), 32'(mem_exp[i]));
        end

        // R9: enable lasts one strobe period only
        bl_sel = 2'd0;
        wr_burst = 1'b1;
        do_pair(16'h0101, 2'b00, 16'h0202, 2'b00);
        check(beat_we == 4'hF, "R9", "pulse present", 32'(beat_we), 32'hF);
        wr_burst = 1'b0;
        do_pair(16'h0303, 2'b00, 16'h0404, 2'b00);
        check(beat_we == 4'h0, "R9", "pulse gone", 32'(beat_we), 32'h0);

        // R5: numbering restarts at 0 after an idle rising edge
        bl_sel = 2'd2;
        wr_burst = 1'b1;
        do_pair(16'h1000, 2'b00, 16'h1001, 2'b00);
        do_pair(16'h1002, 2'b00, 16'h1003, 2'b00);
        check(beat_idx == 3'd2, "R1", "second pair index", 32'(beat_idx), 32'd2);
        wr_burst = 1'b0;
        do_pair(16'h0, 2'b00, 16'h0, 2'b00);
        wr_burst = 1'b1;
        do_pair(16'h2000, 2'b00, 16'h2001, 2'b00);
        check(beat_idx == 3'd0, "R5", "restart index", 32'(beat_idx), 32'd0);

        // R6: reset in the middle of a burst
        do_pair(16'h2002, 2'b00, 16'h2003, 2'b00);
        rst_n = 1'b0;
        do_pair(16'h2004, 2'b00, 16'h2005, 2'b00);
        check(beat_we == 4'h0, "R6", "we after mid-burst reset", 32'(beat_we), 32'h0);
        check(beat_data == 32'h0, "R6", "data after mid-burst reset", beat_data, 32'h0);
        rst_n = 1'b1;
        do_pair(16'h3000, 2'b01, 16'h3001, 2'b10);
        check(beat_idx == 3'd0, "R6", "count cleared by reset", 32'(beat_idx), 32'd0);
        check(beat_we == 4'b0110, "R7", "lane mapping", 32'(beat_we), 32'h6);
        wr_burst = 1'b0;
        do_pair(16'h0, 2'b00, 16'h0, 2'b00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule